// File: doc/BRIEF.md
# Reset Source Capture Controller

This block gathers up to 32 reset-request lines, which are already synchronous to its clock, and decides when the system goes into reset and what kind of reset it is. Each line has five per-source settings: an enable, a hold mode, a hot-type bit, a cold-type bit and a sticky cause flag. A small word-indexed register port lets software program these settings. The same port shows the live level of every line and the causes of the most recent reset.

When an enabled line that has not yet been serviced goes high, the block asserts its system reset request for a minimum stretch of cycles. In that same cycle it records the lines that caused the reset and reports an encoded reset kind: hot, warm or cold. A line in hold mode keeps the reset asserted until the line drops. A line not in hold mode releases the reset after the minimum stretch, even while it stays high.

A software countdown register drives the top source line, so software can request a delayed reset. Software can also cancel that request before it fires. All registers are cleared only by the power-on reset input, never by the resets the block itself requests.

Top module: `rst_cause_ctrl`

## Requirements
- R1: Word 1 (byte offset 0x04) reads the live level of every source line, with bit 31 also high while the software countdown is firing. Writes to word 1 have no effect.
- R2: A source line can start a reset only while its bit in the enable register (word 3, offset 0x0C) is 1.
- R3: `sys_rst_req` rises on the clock edge that samples a new enabled request. When no held source remains active, it stays high for exactly 16 cycles.
- R4: A triggering source whose hold bit (word 2, offset 0x08) is 1 keeps `sys_rst_req` high until that source deasserts, measured from the point the 16 cycles have passed.
- R5: A source that caused a reset starts no further reset until it has gone low and then high again.
- R6: The cause flag register (word 0, offset 0x00) sets the bits of the triggering sources on the same edge that reset is entered. Writing 1 to a bit clears it, and a set on the same edge wins over the clear.
- R7: `rst_kind` is 0 when no reset is requested, 1 for hot, 2 for warm and 3 for cold. A source whose hot bit (word 4, offset 0x10) is 1 gives hot whatever its cold bit is. Otherwise its cold bit (word 5, offset 0x14) selects cold (1) or warm (0).
- R8: When several enabled sources trigger together, the most severe kind is used: cold over warm, and warm over hot.
- R9: The software countdown (word 7, offset 0x1C) loads on a write and then decrements once per cycle, stopping at 0. While it holds 2 it drives source line 31. Writing 0 cancels a pending request.
- R10: All registers read 0 after power-on reset, and a reset requested by the block leaves them unchanged.
- R11: Word 6 (offset 0x18) is reserved: it reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| src_i | input | 32 | Reset request lines, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_widx | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the indexed word, combinational |
| sys_rst_req | output | 1 | System reset request |
| rst_kind | output | 2 | Reset kind: 0 none, 1 hot, 2 warm, 3 cold |

## Verification
The bench runs a hold-mode source for longer than the minimum stretch. A design that ignores hold would release reset early, and a design that ignores the minimum would release it as soon as the source dropped. It keeps a non-hold source high well past its reset to catch a design that re-enters reset in a loop. It fires sources with mixed types together, where a wrong priority shows up as the wrong kind code. It also sets the hot and cold bits together, where a design that lets cold win would report 3 instead of 1. Finally, it cancels the software countdown and clears flags by writing 1, which catches a missed cancel, a flag lost on a same-edge clear, and configuration that a generated reset wipes.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_HOT  = 2'd1,
        KIND_WARM = 2'd2,
        KIND_COLD = 2'd3
    } rst_kind_e;

    typedef enum logic {
        SEQ_RUN = 1'b0,
        SEQ_RST = 1'b1
    } seq_state_e;

    localparam logic [2:0] W_FLAG = 3'd0;
    localparam logic [2:0] W_STAT = 3'd1;
    localparam logic [2:0] W_HOLD = 3'd2;
    localparam logic [2:0] W_EN   = 3'd3;
    localparam logic [2:0] W_HOT  = 3'd4;
    localparam logic [2:0] W_COLD = 3'd5;
    localparam logic [2:0] W_RSVD = 3'd6;
    localparam logic [2:0] W_SWC  = 3'd7;

    function automatic rst_kind_e kind_of(input logic hot_b, input logic cold_b);
        if (hot_b)       return KIND_HOT;
        else if (cold_b) return KIND_COLD;
        else             return KIND_WARM;
    endfunction

endpackage

// File: rtl/rcc_regs.sv
module rcc_regs
    import rcc_pkg::*;
#(
    parameter int unsigned NSRC = 32,
    parameter int unsigned DW   = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [2:0]      widx,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] src_live,
    input  logic [NSRC-1:0] cap_mask,
    output logic [NSRC-1:0] en,
    output logic [NSRC-1:0] hold,
    output logic [NSRC-1:0] hot,
    output logic [NSRC-1:0] cold,
    output logic            sw_fire,
    output logic [DW-1:0]   rdata
);
    localparam logic [DW-1:0] FIRE_VAL = DW'(2);

    logic [NSRC-1:0] flags;
    logic [DW-1:0]   swc;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            en    <= '0;
            hold  <= '0;
            hot   <= '0;
            cold  <= '0;
            swc   <= '0;
        end else begin
            if (wr && widx == W_FLAG) flags <= (flags & ~wdata[NSRC-1:0]) | cap_mask;
            else                      flags <= flags | cap_mask;
            if (wr && widx == W_EN)   en   <= wdata[NSRC-1:0];
            if (wr && widx == W_HOLD) hold <= wdata[NSRC-1:0];
            if (wr && widx == W_HOT)  hot  <= wdata[NSRC-1:0];
            if (wr && widx == W_COLD) cold <= wdata[NSRC-1:0];
            if (wr && widx == W_SWC)  swc  <= wdata;
            else if (swc != '0)       swc  <= swc - 1'b1;
        end
    end

    assign sw_fire = (swc == FIRE_VAL);

    always_comb begin
        rdata = '0;
        case (widx)
            W_FLAG:  rdata = DW'(flags);
            W_STAT:  rdata = DW'(src_live);
            W_HOLD:  rdata = DW'(hold);
            W_EN:    rdata = DW'(en);
            W_HOT:   rdata = DW'(hot);
            W_COLD:  rdata = DW'(cold);
            W_SWC:   rdata = swc;
            default: rdata = '0;
        endcase
    end

    assert_flag_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (|cap_mask) |=> ((flags & $past(cap_mask)) == $past(cap_mask)));

    assert_countdown_stops_R9: assert property (@(posedge clk) disable iff (rst)
        (swc == '0 && !(wr && widx == W_SWC)) |=> (swc == '0));

    assert_countdown_step_R9: assert property (@(posedge clk) disable iff (rst)
        (swc != '0 && !(wr && widx == W_SWC)) |=> (swc == $past(swc) - 1'b1));

endmodule

// File: rtl/rcc_seq.sv
module rcc_seq
    import rcc_pkg::*;
#(
    parameter int unsigned NSRC    = 32,
    parameter int unsigned MIN_CYC = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] hold,
    input  logic [NSRC-1:0] hot,
    input  logic [NSRC-1:0] cold,
    output logic [NSRC-1:0] cap_mask,
    output logic            rst_req,
    output rst_kind_e       kind
);
    localparam int unsigned CW   = $clog2(MIN_CYC) + 1;
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

    seq_state_e      state;
    logic [CW-1:0]   cnt;
    logic [NSRC-1:0] served;
    logic [NSRC-1:0] held;
    logic [NSRC-1:0] trig;
    rst_kind_e       kind_q;
    rst_kind_e       kind_n;
    logic            release_ok;

    assign trig       = src & en & ~served;
    assign cap_mask   = (state == SEQ_RUN) ? trig : '0;
    assign release_ok = (cnt == LAST) && ((held & src) == '0);

    always_comb begin
        kind_n = KIND_NONE;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (trig[i] && kind_of(hot[i], cold[i]) > kind_n)
                kind_n = kind_of(hot[i], cold[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_RUN;
            cnt    <= '0;
            served <= '0;
            held   <= '0;
            kind_q <= KIND_NONE;
        end else begin
            case (state)
                SEQ_RUN: begin
                    served <= (served & src) | trig;
                    if (|trig) begin
                        state  <= SEQ_RST;
                        cnt    <= '0;
                        held   <= trig & hold;
                        kind_q <= kind_n;
                    end
                end
                SEQ_RST: begin
                    served <= served & src;
                    if (release_ok) begin
                        state  <= SEQ_RUN;
                        kind_q <= KIND_NONE;
                        held   <= '0;
                    end else if (cnt != LAST) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_RUN;
            endcase
        end
    end

    assign rst_req = (state == SEQ_RST);
    assign kind    = kind_q;

    assert_min_width_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req) |-> ($past(cnt) == LAST));

    assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (rst_req && (|(held & src))) |=> rst_req);

    assert_enable_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && ((src & en) == '0)) |=> !rst_req);

    assert_kind_valid_R7: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (kind != KIND_NONE));

    assert_kind_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !rst_req |-> (kind == KIND_NONE));

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int unsigned NSRC    = 32,
    parameter int unsigned DW      = 32,
    parameter int unsigned MIN_CYC = 16
) (
    input  logic            clk,
    input  logic            por_rst,
    input  logic [NSRC-1:0] src_i,
    input  logic            bus_wr,
    input  logic [2:0]      bus_widx,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            sys_rst_req,
    output logic [1:0]      rst_kind
);
    logic [NSRC-1:0] src_eff;
    logic [NSRC-1:0] en, hold, hot, cold, cap_mask;
    logic            sw_fire;
    rst_kind_e       kind;

    assign src_eff = {src_i[NSRC-1] | sw_fire, src_i[NSRC-2:0]};

    rcc_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
        .clk      (clk),
        .rst      (por_rst),
        .wr       (bus_wr),
        .widx     (bus_widx),
        .wdata    (bus_wdata),
        .src_live (src_eff),
        .cap_mask (cap_mask),
        .en       (en),
        .hold     (hold),
        .hot      (hot),
        .cold     (cold),
        .sw_fire  (sw_fire),
        .rdata    (bus_rdata)
    );

    rcc_seq #(.NSRC(NSRC), .MIN_CYC(MIN_CYC)) u_seq (
        .clk      (clk),
        .rst      (por_rst),
        .src      (src_eff),
        .en       (en),
        .hold     (hold),
        .hot      (hot),
        .cold     (cold),
        .cap_mask (cap_mask),
        .rst_req  (sys_rst_req),
        .kind     (kind)
    );

    assign rst_kind = kind;

endmodule

// File: tb/tb_rst_cause_ctrl.sv
module tb_rst_cause_ctrl;
    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic [31:0] src_i = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_widx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_rst_req;
    logic [1:0]  rst_kind;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rst_cause_ctrl dut (
        .clk(clk), .por_rst(por_rst), .src_i(src_i), .bus_wr(bus_wr),
        .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_rst_req(sys_rst_req), .rst_kind(rst_kind)
    );

    // behavioural reference
    bit [31:0] m_reg [0:7];
    bit [31:0] m_armed_off;
    bit [31:0] m_held;
    bit        m_rst;
    int        m_kind;
    int        m_age;

    function automatic bit [31:0] m_src_eff();
        return src_i | ((m_reg[7] == 32'd2) ? 32'h8000_0000 : 32'h0);
    endfunction

    always @(posedge clk) begin
        bit [31:0] se, tr, w1c;
        int k;
        se = m_src_eff();
        if (por_rst) begin
            for (int i = 0; i < 8; i++) m_reg[i] = '0;
            m_armed_off = '0; m_held = '0; m_rst = 0; m_kind = 0; m_age = 0;
        end else begin
            tr = '0;
            if (!m_rst) begin
                tr = se & m_reg[3] & ~m_armed_off;
                m_armed_off = (m_armed_off & se) | tr;
                if (tr != 0) begin
                    m_rst = 1; m_age = 0; m_held = tr & m_reg[2]; m_kind = 0;
                    for (int i = 0; i < 32; i++) if (tr[i]) begin
                        k = m_reg[4][i] ? 1 : (m_reg[5][i] ? 3 : 2);
                        if (k > m_kind) m_kind = k;
                    end
                end
            end else begin
                m_armed_off = m_armed_off & se;
                if (m_age == 15 && (m_held & se) == 0) begin
                    m_rst = 0; m_kind = 0;
                end else if (m_age < 15) m_age++;
            end
            w1c = (bus_wr && bus_widx == 3'd0) ? bus_wdata : 32'h0;
            m_reg[0] = (m_reg[0] & ~w1c) | tr;
            if (bus_wr && bus_widx inside {3'd2, 3'd3, 3'd4, 3'd5}) m_reg[bus_widx] = bus_wdata;
            if (bus_wr && bus_widx == 3'd7) m_reg[7] = bus_wdata;
            else if (m_reg[7] != 0) m_reg[7] = m_reg[7] - 1;
        end
    end

    // run-length monitor
    int run = 0, last_len = 0, runs = 0, last_kind = 0;
    always @(negedge clk) begin
        if (sys_rst_req) begin
            if (run == 0) begin runs++; last_kind = int'(rst_kind); end
            run++;
        end else if (run != 0) begin
            last_len = run; run = 0;
        end
    end

    // per-cycle compare against the reference (R3 R4 R7)
    always @(negedge clk) begin
        if (!por_rst && !done) begin
            n_chk++;
            if (sys_rst_req !== m_rst || int'(rst_kind) != m_kind) begin
                n_bad++;
                $display("FAIL R3/R4/R7 cycle compare: req=%0b kind=%0d expected req=%0b kind=%0d",
                         sys_rst_req, rst_kind, m_rst, m_kind);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_widx = idx; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input string req, input logic [2:0] idx, input logic [31:0] exp);
        @(negedge clk); bus_widx = idx; #1;
        check(req, int'(bus_rdata), int'(exp));
        check({req, " model"}, int'(bus_rdata), int'((idx == 3'd1) ? m_src_eff() : (idx == 3'd6 ? 32'h0 : m_reg[idx])));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        por_rst = 0;
        // R10 / R11: reset state
        check("R10 req after por", int'(sys_rst_req), 0);
        for (int i = 0; i < 8; i++) rd("R10 reg zero", 3'(i), 32'h0);
        wr(3'd3, 32'h0001_0011);
        wr(3'd2, 32'h0001_0000);
        wr(3'd4, 32'h0000_0010);
        wr(3'd5, 32'h0000_0011);
        wr(3'd6, 32'hFFFF_FFFF);
        rd("R11 reserved reads 0", 3'd6, 32'h0);
        rd("R10 enable readback", 3'd3, 32'h0001_0011);
        // R1 / R2: unenabled source
        r0 = runs;
        @(negedge clk); src_i = 32'h20;
        rd("R1 status live", 3'd1, 32'h20);
        wr(3'd1, 32'h0);
        rd("R1 status write ignored", 3'd1, 32'h20);
        @(negedge clk); src_i = 0;
        idle(3);
        check("R2 disabled source no reset", runs, r0);
        rd("R2 no flag", 3'd0, 32'h0);
        // R3 / R7: hot with cold also set
        @(negedge clk); src_i = 32'h10;
        @(negedge clk); src_i = 0;
        idle(20);
        check("R3 min length", last_len, 16);
        check("R7 hot wins over cold bit", last_kind, 1);
        rd("R6 flag set", 3'd0, 32'h10);
        // R4: hold source kept 40 cycles
        @(negedge clk); src_i = 32'h1_0000;
        idle(39);
        check("R4 still held", int'(sys_rst_req), 1);
        @(negedge clk); src_i = 0;
        idle(3);
        check("R4 hold length", last_len, 40);
        check("R7 warm", last_kind, 2);
        // R5: non-hold source stays high
        r0 = runs;
        @(negedge clk); src_i = 32'h1;
        idle(40);
        check("R5 released while active", int'(sys_rst_req), 0);
        check("R5 single run", runs - r0, 1);
        check("R3 non-hold length", last_len, 16);
        check("R7 cold", last_kind, 3);
        @(negedge clk); src_i = 0;
        idle(2);
        // R8: combined severity
        @(negedge clk); src_i = 32'h1_0010;
        @(negedge clk); src_i = 0;
        idle(20);
        check("R8 warm over hot", last_kind, 2);
        @(negedge clk); src_i = 32'h11;
        @(negedge clk); src_i = 0;
        idle(20);
        check("R8 cold over hot", last_kind, 3);
        // R6: write-one-to-clear
        rd("R6 flags accumulated", 3'd0, 32'h1_0011);
        wr(3'd0, 32'h10);
        rd("R6 w1c", 3'd0, 32'h1_0001);
        // R6 set wins over same-edge clear
        @(negedge clk); src_i = 32'h10; bus_wr = 1; bus_widx = 3'd0; bus_wdata = 32'h10;
        @(negedge clk); src_i = 0; bus_wr = 0;
        idle(20);
        rd("R6 set beats clear", 3'd0, 32'h1_0011);
        // R9: software countdown
        wr(3'd3, 32'h8001_0011);
        r0 = runs;
        wr(3'd7, 32'd5);
        idle(25);
        check("R9 software reset fired", runs - r0, 1);
        check("R9 software kind warm", last_kind, 2);
        rd("R9 counter at zero", 3'd7, 32'h0);
        rd("R9 software flag", 3'd0, 32'h8001_0011);
        r0 = runs;
        wr(3'd7, 32'd20);
        idle(3);
        wr(3'd7, 32'd0);
        idle(30);
        check("R9 cancel", runs - r0, 0);
        // R10: generated resets kept config; por clears it
        rd("R10 enable kept", 3'd3, 32'h8001_0011);
        rd("R10 hot kept", 3'd4, 32'h10);
        @(negedge clk); por_rst = 1;
        idle(2);
        @(negedge clk); por_rst = 0;
        rd("R10 flags cleared by por", 3'd0, 32'h0);
        rd("R10 enable cleared by por", 3'd3, 32'h0);
        idle(2);
        summary();
    end
endmodule